// File: doc/BRIEF.md
# PCI Interrupt Line Router

The router steers four shared, level-sensitive PCI interrupt lines onto sixteen legacy interrupt controller inputs. Each line owns an 8-bit steering register written through a byte-wide configuration write port on a 32-bit data bus. A steering value below sixteen names the controller input the line drives. A value of sixteen or more detaches the line completely.

Internally the block keeps a level map with one bit for each pair of controller input and line. The whole map is rebuilt from the current steering registers and line levels on every clock. As a result, a line that is rerouted while it is asserted never leaves a stale level on its old input. Each controller output is the OR of the map bits that belong to it.

Two combinational helpers sit beside the datapath. A route query port reports, for a chosen line, whether it is connected and to which input. A slot swizzle turns a device's interrupt pin and its device/function number into the index of the line it uses.

Top module: `pirq_router`

## Requirements
- R1: After reset every steering register holds 0x80, every `irq_out` bit is low, and the query port reports every line as disconnected.
- R2: The steering registers sit at configuration byte addresses 0x60 to 0x63. The write address selects a 32-bit word and its two low bits are ignored, so word 0x60 carries line k in byte lane k (line A = lane 0, bits 7:0; line D = lane 3, bits 31:24). Only lanes whose `cfg_be` bit is set are written.
- R3: A write to any other word, or a cycle with `cfg_wr_en` low, leaves every steering register unchanged.
- R4: A steering value from 0 to 15 makes that line, when asserted, drive `irq_out` bit equal to the value. Both ends of the range, 0 and 15, are valid.
- R5: A steering value of 16 or more detaches the line. It drives no output, and the query reports `qry_en` = 0 with `qry_irq` = 4'hF, the all-ones code that stands for "none".
- R6: An `irq_out` bit is high exactly when at least one asserted line is steered to it. With several lines on one input, the input stays high until the last of them drops.
- R7: A change on `pirq_in` appears on `irq_out` after one rising clock edge. A steering write sampled at one edge takes effect on `irq_out` at the following edge.
- R8: Rerouting an asserted line moves its level: the old input drops and the new one rises on the same edge, and no stale bit is left behind.
- R9: The query port is combinational. For line `qry_pin` it returns `qry_en` = 1 and the steering value in `qry_irq` when that value is below 16.
- R10: The swizzle returns `swz_pirq` = (`swz_intx` + `swz_devfn`[7:3] - 1) mod 4, where `swz_intx` 0 to 3 stands for pins A to D. Slot 0 therefore maps pin A to line D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address; bits 1:0 are ignored |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte-lane write enables |
| pirq_in | input | 4 | Shared interrupt line levels, A in bit 0 |
| irq_out | output | 16 | Controller input levels |
| qry_pin | input | 2 | Line index for the route query |
| qry_en | output | 1 | Queried line is connected |
| qry_irq | output | 4 | Controller input of the queried line, 4'hF when detached |
| swz_devfn | input | 8 | Device/function number for the swizzle |
| swz_intx | input | 2 | Device interrupt pin, 0 = A |
| swz_pirq | output | 2 | Line index chosen by the swizzle |

## Verification
The steering function is exercised with four distinct routes and one line asserted at a time, which separates the lines from each other and catches swapped byte lanes. Two lines are then steered to one input and released in turn, which separates a true OR from a last-writer-wins update. An asserted line is rerouted and sampled at the intermediate edge and at the settling edge, which exposes both stale levels and wrong latency. The detach codes 16 and 255 and the boundary value 15 distinguish a test on the full byte from a test on the low nibble alone. A sweep over every slot and pin checks the swizzle, including the wrap at slot 0.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

   localparam int unsigned BYTE_W = 8;

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
   import pirq_router_pkg::*;
#(
   parameter int unsigned NUM_LINES  = 4,
   parameter int unsigned ROUTE_W    = 8,
   parameter int unsigned CFG_AW     = 8,
   parameter int unsigned CFG_DW     = 32,
   parameter int unsigned ROUTE_BASE = 32'h60,
   parameter logic [ROUTE_W-1:0] ROUTE_RST = 8'h80
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [CFG_AW-1:0]             addr,
   input  logic [CFG_DW-1:0]             wdata,
   input  logic [CFG_DW/BYTE_W-1:0]      be,
   output logic [NUM_LINES*ROUTE_W-1:0]  routes_o
);
   localparam int unsigned BE_W   = CFG_DW / BYTE_W;
   localparam int unsigned LANE_W = $clog2(BE_W);
   localparam int unsigned WIDX_W = CFG_AW - LANE_W;

   logic [WIDX_W-1:0] word_idx;
   logic              unused_lane_bits;

   assign word_idx         = addr[CFG_AW-1:LANE_W];
   assign unused_lane_bits = ^addr[LANE_W-1:0];

   for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_route
      localparam int unsigned      BYTE_ADDR = ROUTE_BASE + gi;
      localparam int unsigned      LANE      = BYTE_ADDR % BE_W;
      localparam logic [WIDX_W-1:0] WORD     = WIDX_W'(BYTE_ADDR / BE_W);

      logic               hit;
      logic [ROUTE_W-1:0] route_q;

      assign hit = wr_en && (word_idx == WORD) && be[LANE];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            route_q <= ROUTE_RST;
         end else if (hit) begin
            route_q <= wdata[LANE*BYTE_W +: ROUTE_W];
         end
      end

      assign routes_o[gi*ROUTE_W +: ROUTE_W] = route_q;
   end

endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map #(
   parameter int unsigned NUM_LINES = 4,
   parameter int unsigned NUM_IRQS  = 16,
   parameter int unsigned ROUTE_W   = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_LINES*ROUTE_W-1:0]  routes_i,
   input  logic [NUM_LINES-1:0]          lines_i,
   output logic [NUM_IRQS-1:0]           irq_o
);
   localparam int unsigned MAP_W = NUM_LINES * NUM_IRQS;

   // bit (irq * NUM_LINES + line) is set when that line is high and steered to irq
   logic [MAP_W-1:0] map_d;
   logic [MAP_W-1:0] map_q;

   always_comb begin
      for (int j = 0; j < NUM_IRQS; j++) begin
         for (int i = 0; i < NUM_LINES; i++) begin
            map_d[j*NUM_LINES + i] = lines_i[i] &&
               (routes_i[i*ROUTE_W +: ROUTE_W] == ROUTE_W'(j));
         end
      end
   end

   // full rebuild each cycle: no stale bit survives a reroute
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q <= '0;
      end else begin
         map_q <= map_d;
      end
   end

   for (genvar gj = 0; gj < NUM_IRQS; gj++) begin : g_or
      assign irq_o[gj] = |map_q[gj*NUM_LINES +: NUM_LINES];
   end

endmodule

// File: rtl/pirq_route_query.sv
module pirq_route_query #(
   parameter int unsigned NUM_LINES = 4,
   parameter int unsigned NUM_IRQS  = 16,
   parameter int unsigned ROUTE_W   = 8,
   localparam int unsigned LINE_W   = $clog2(NUM_LINES),
   localparam int unsigned IRQ_W    = $clog2(NUM_IRQS)
) (
   input  logic [NUM_LINES*ROUTE_W-1:0]  routes_i,
   input  logic [LINE_W-1:0]             pin_i,
   output logic                          en_o,
   output logic [IRQ_W-1:0]              irq_o
);
   logic [ROUTE_W-1:0] sel;

   assign sel   = routes_i[pin_i*ROUTE_W +: ROUTE_W];
   assign en_o  = {1'b0, sel} < (ROUTE_W+1)'(NUM_IRQS);
   assign irq_o = en_o ? sel[IRQ_W-1:0] : '1;

endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
   parameter int unsigned NUM_LINES = 4,
   parameter int unsigned DEVFN_W   = 8,
   parameter int unsigned FUNC_W    = 3,
   localparam int unsigned LINE_W   = $clog2(NUM_LINES)
) (
   input  logic [DEVFN_W-1:0] devfn_i,
   input  logic [LINE_W-1:0]  intx_i,
   output logic [LINE_W-1:0]  pirq_o
);
   logic [DEVFN_W-FUNC_W-1:0] slot;
   logic                      unused_devfn_bits;

   assign slot = devfn_i[DEVFN_W-1:FUNC_W];

   if (DEVFN_W - FUNC_W > LINE_W) begin : g_wide_slot
      assign unused_devfn_bits = ^{devfn_i[FUNC_W-1:0], slot[DEVFN_W-FUNC_W-1:LINE_W]};
   end else begin : g_narrow_slot
      assign unused_devfn_bits = ^devfn_i[FUNC_W-1:0];
   end

   // modulo NUM_LINES by natural wrap of LINE_W bits
   assign pirq_o = intx_i + slot[LINE_W-1:0] - LINE_W'(1);

endmodule

// File: rtl/pirq_router.sv
module pirq_router
   import pirq_router_pkg::*;
#(
   parameter int unsigned NUM_LINES  = 4,
   parameter int unsigned NUM_IRQS   = 16,
   parameter int unsigned ROUTE_W    = 8,
   parameter int unsigned CFG_AW     = 8,
   parameter int unsigned CFG_DW     = 32,
   parameter int unsigned ROUTE_BASE = 32'h60,
   parameter logic [7:0]  ROUTE_RST  = 8'h80,
   parameter int unsigned DEVFN_W    = 8,
   parameter int unsigned FUNC_W     = 3,
   localparam int unsigned LINE_W    = $clog2(NUM_LINES),
   localparam int unsigned IRQ_W     = $clog2(NUM_IRQS),
   localparam int unsigned BE_W      = CFG_DW / BYTE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr_en,
   input  logic [CFG_AW-1:0]     cfg_addr,
   input  logic [CFG_DW-1:0]     cfg_wdata,
   input  logic [BE_W-1:0]       cfg_be,
   input  logic [NUM_LINES-1:0]  pirq_in,
   output logic [NUM_IRQS-1:0]   irq_out,
   input  logic [LINE_W-1:0]     qry_pin,
   output logic                  qry_en,
   output logic [IRQ_W-1:0]      qry_irq,
   input  logic [DEVFN_W-1:0]    swz_devfn,
   input  logic [LINE_W-1:0]     swz_intx,
   output logic [LINE_W-1:0]     swz_pirq
);
   if (ROUTE_W != BYTE_W) begin : g_bad_route_w
      $error("steering registers must be one byte wide");
   end
   if (!is_pow2(NUM_LINES) || NUM_LINES < 2) begin : g_bad_lines
      $error("NUM_LINES must be a power of two, at least 2");
   end
   if (!is_pow2(NUM_IRQS) || NUM_IRQS > (1 << ROUTE_W)) begin : g_bad_irqs
      $error("NUM_IRQS must be a power of two that a steering byte can name");
   end
   if (!is_pow2(BE_W) || (CFG_DW % BYTE_W) != 0) begin : g_bad_dw
      $error("CFG_DW must be a power-of-two number of bytes");
   end
   if (ROUTE_BASE + NUM_LINES > (1 << CFG_AW)) begin : g_bad_base
      $error("steering registers fall outside the configuration space");
   end
   if (DEVFN_W <= FUNC_W) begin : g_bad_devfn
      $error("device/function number has no slot field");
   end

   logic [NUM_LINES*ROUTE_W-1:0] route_vec;

   pirq_route_regs #(
      .NUM_LINES (NUM_LINES),
      .ROUTE_W   (ROUTE_W),
      .CFG_AW    (CFG_AW),
      .CFG_DW    (CFG_DW),
      .ROUTE_BASE(ROUTE_BASE),
      .ROUTE_RST (ROUTE_W'(ROUTE_RST))
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .addr    (cfg_addr),
      .wdata   (cfg_wdata),
      .be      (cfg_be),
      .routes_o(route_vec)
   );

   pirq_level_map #(
      .NUM_LINES(NUM_LINES),
      .NUM_IRQS (NUM_IRQS),
      .ROUTE_W  (ROUTE_W)
   ) map_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .routes_i(route_vec),
      .lines_i (pirq_in),
      .irq_o   (irq_out)
   );

   pirq_route_query #(
      .NUM_LINES(NUM_LINES),
      .NUM_IRQS (NUM_IRQS),
      .ROUTE_W  (ROUTE_W)
   ) query_i (
      .routes_i(route_vec),
      .pin_i   (qry_pin),
      .en_o    (qry_en),
      .irq_o   (qry_irq)
   );

   pirq_swizzle #(
      .NUM_LINES(NUM_LINES),
      .DEVFN_W  (DEVFN_W),
      .FUNC_W   (FUNC_W)
   ) swz_i (
      .devfn_i(swz_devfn),
      .intx_i (swz_intx),
      .pirq_o (swz_pirq)
   );

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
   parameter int unsigned NUM_LINES  = 4,
   parameter int unsigned NUM_IRQS   = 16,
   parameter int unsigned ROUTE_W    = 8,
   parameter int unsigned CFG_AW     = 8,
   parameter int unsigned ROUTE_BASE = 32'h60,
   parameter logic [7:0]  ROUTE_RST  = 8'h80,
   parameter int unsigned DEVFN_W    = 8,
   parameter int unsigned FUNC_W     = 3,
   localparam int unsigned LINE_W    = $clog2(NUM_LINES),
   localparam int unsigned IRQ_W     = $clog2(NUM_IRQS)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          cfg_wr_en,
   input logic [CFG_AW-1:0]             cfg_addr,
   input logic [NUM_LINES-1:0]          pirq_in,
   input logic [NUM_IRQS-1:0]           irq_out,
   input logic                          qry_en,
   input logic [IRQ_W-1:0]              qry_irq,
   input logic [DEVFN_W-1:0]            swz_devfn,
   input logic [LINE_W-1:0]             swz_intx,
   input logic [LINE_W-1:0]             swz_pirq,
   input logic [NUM_LINES*ROUTE_W-1:0]  routes
);
   localparam int unsigned FIRST_WORD = ROUTE_BASE / 4;
   localparam int unsigned LAST_WORD  = (ROUTE_BASE + NUM_LINES - 1) / 4;

   logic route_word;
   assign route_word = (int'(cfg_addr) / 4 >= FIRST_WORD) &&
                       (int'(cfg_addr) / 4 <= LAST_WORD);

   // R1: steering registers come out of reset at the disconnected code
   assert_reset_routes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> routes == {NUM_LINES{ROUTE_W'(ROUTE_RST)}});

   // R3: no write strobe, or a strobe outside the steering words, changes nothing
   assert_no_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr_en || !route_word) |=> $stable(routes));

   // R5: a disconnected query always reports the all-ones code
   assert_detached_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !qry_en |-> qry_irq == '1);

   // R6: every high output needs a high line one edge earlier
   assert_no_phantom_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_out) |-> $past(|pirq_in));

   // R8: a line drives at most one output, so outputs never outnumber lines
   assert_single_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(irq_out) <= $past($countones(pirq_in)));

   // R10: slot 1 passes the pin straight through
   assert_slot1_identity_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (swz_devfn[DEVFN_W-1:FUNC_W] == 1) |-> swz_pirq == swz_intx);

endmodule

bind pirq_router pirq_router_chk #(
   .NUM_LINES (NUM_LINES),
   .NUM_IRQS  (NUM_IRQS),
   .ROUTE_W   (ROUTE_W),
   .CFG_AW    (CFG_AW),
   .ROUTE_BASE(ROUTE_BASE),
   .ROUTE_RST (ROUTE_RST),
   .DEVFN_W   (DEVFN_W),
   .FUNC_W    (FUNC_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_wr_en(cfg_wr_en),
   .cfg_addr (cfg_addr),
   .pirq_in  (pirq_in),
   .irq_out  (irq_out),
   .qry_en   (qry_en),
   .qry_irq  (qry_irq),
   .swz_devfn(swz_devfn),
   .swz_intx (swz_intx),
   .swz_pirq (swz_pirq),
   .routes   (route_vec)
);

// File: tb/pirq_router_tb.sv
module pirq_router_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [3:0]  cfg_be = '0;
   logic [3:0]  pirq_in = '0;
   logic [15:0] irq_out;
   logic [1:0]  qry_pin = '0;
   logic        qry_en;
   logic [3:0]  qry_irq;
   logic [7:0]  swz_devfn = '0;
   logic [1:0]  swz_intx = '0;
   logic [1:0]  swz_pirq;

   int n_checks = 0;
   int n_errors = 0;
   logic [7:0] m_route [4];

   always #5 clk = ~clk;

   pirq_router dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
      .pirq_in(pirq_in), .irq_out(irq_out),
      .qry_pin(qry_pin), .qry_en(qry_en), .qry_irq(qry_irq),
      .swz_devfn(swz_devfn), .swz_intx(swz_intx), .swz_pirq(swz_pirq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_irq(input logic [3:0] lines);
      logic [15:0] r = '0;
      for (int i = 0; i < 4; i++) begin
         if (lines[i] && m_route[i] < 8'd16) r[m_route[i][3:0]] = 1'b1;
      end
      return r;
   endfunction

   task automatic check_queries(input string tag);
      for (int p = 0; p < 4; p++) begin
         qry_pin = 2'(p);
         #1;
         check({tag, " query en"}, 32'(qry_en), 32'(m_route[p] < 8'd16));
         check({tag, " query irq"}, 32'(qry_irq),
               (m_route[p] < 8'd16) ? 32'(m_route[p][3:0]) : 32'hF);
      end
   endtask

   task automatic check_outputs(input string tag);
      check({tag, " irq_out"}, 32'(irq_out), 32'(exp_irq(pirq_in)));
   endtask

   // returns one edge after the write edge, when the outputs have settled
   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
      @(posedge clk); #1;
      cfg_wr_en = 1'b0;
      if (a[7:2] == 6'h18) begin
         for (int l = 0; l < 4; l++) if (be[l]) m_route[l] = d[l*8 +: 8];
      end
      @(posedge clk); #1;
   endtask

   task automatic set_lines(input logic [3:0] v);
      pirq_in = v;
      @(posedge clk); #1;
   endtask

   task automatic t_reset;
      for (int l = 0; l < 4; l++) m_route[l] = 8'h80;
      check("R1 reset irq_out", 32'(irq_out), 32'h0);
      check_queries("R1 reset");
   endtask

   task automatic t_basic_routes;
      cfg_write(8'h60, 32'h0B09_0503, 4'hF);
      check_queries("R2 R9 full write");
      for (int l = 0; l < 4; l++) begin
         set_lines(4'(1 << l));
         check_outputs("R4 single line");
      end
      set_lines(4'hF);
      check_outputs("R4 all lines");
      set_lines(4'h0);
   endtask

   task automatic t_partial_write;
      cfg_write(8'h60, 32'hFFFF_07FF, 4'b0100);
      check_queries("R2 lane 2 only");
      set_lines(4'b0100);
      check_outputs("R2 lane 2 route");
      set_lines(4'h0);
   endtask

   task automatic t_ignored_writes;
      cfg_write(8'h64, 32'h0000_0000, 4'hF);
      cfg_write(8'h5C, 32'h0000_0000, 4'hF);
      @(negedge clk);
      cfg_addr = 8'h60; cfg_wdata = 32'h0; cfg_be = 4'hF; cfg_wr_en = 1'b0;
      @(posedge clk); #1;
      @(posedge clk); #1;
      check_queries("R3 ignored writes");
      set_lines(4'b0001);
      check_outputs("R3 routes unchanged");
      set_lines(4'h0);
   endtask

   task automatic t_wired_or;
      cfg_write(8'h60, 32'h0B09_0404, 4'hF);
      set_lines(4'b0011);
      check_outputs("R6 two lines one input");
      check("R6 bit 4 high", 32'(irq_out[4]), 32'h1);
      set_lines(4'b0010);
      check("R6 held by remaining line", 32'(irq_out[4]), 32'h1);
      set_lines(4'b0110);
      check_outputs("R6 two inputs");
      set_lines(4'b0000);
      check("R6 last line drops", 32'(irq_out), 32'h0);
   endtask

   task automatic t_detach;
      cfg_write(8'h60, 32'h0010_0000, 4'b0100);
      set_lines(4'b0100);
      check("R5 code 16 drives nothing", 32'(irq_out), 32'h0);
      cfg_write(8'h60, 32'h00FF_0000, 4'b0100);
      check("R5 code 255 drives nothing", 32'(irq_out), 32'h0);
      check_queries("R5 detached");
      cfg_write(8'h60, 32'h0F00_0000, 4'b1000);
      set_lines(4'b1000);
      check("R4 boundary 15", 32'(irq_out), 32'h8000);
      cfg_write(8'h60, 32'h0000_0000, 4'b0001);
      set_lines(4'b0001);
      check("R4 boundary 0", 32'(irq_out), 32'h0001);
      set_lines(4'h0);
   endtask

   task automatic t_reroute;
      cfg_write(8'h60, 32'h0000_0003, 4'b0001);
      set_lines(4'b0001);
      check("R8 before reroute", 32'(irq_out), 32'h0008);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = 8'h60; cfg_wdata = 32'h0000_000C; cfg_be = 4'b0001;
      @(posedge clk); #1;
      cfg_wr_en = 1'b0;
      m_route[0] = 8'h0C;
      check("R7 write edge keeps old route", 32'(irq_out), 32'h0008);
      @(posedge clk); #1;
      check("R8 moved without stale bit", 32'(irq_out), 32'h1000);
      set_lines(4'h0);
   endtask

   task automatic t_latency;
      pirq_in = 4'b0001;
      #2;
      check("R7 not before edge", 32'(irq_out), 32'h0);
      @(posedge clk); #1;
      check("R7 after one edge", 32'(irq_out), 32'h1000);
      pirq_in = 4'b0000;
      #2;
      check("R7 fall not before edge", 32'(irq_out), 32'h1000);
      @(posedge clk); #1;
      check("R7 fall after one edge", 32'(irq_out), 32'h0);
   endtask

   task automatic t_swizzle;
      for (int s = 0; s < 32; s++) begin
         for (int x = 0; x < 4; x++) begin
            swz_devfn = {5'(s), 3'(x + 1)};
            swz_intx  = 2'(x);
            #1;
            check("R10 swizzle", 32'(swz_pirq), 32'((x + s + 3) % 4));
         end
      end
      swz_devfn = 8'h00; swz_intx = 2'd0;
      #1;
      check("R10 slot 0 pin A to line D", 32'(swz_pirq), 32'd3);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_basic_routes();
      t_partial_write();
      t_ignored_writes();
      t_wired_or();
      t_detach();
      t_reroute();
      t_latency();
      t_swizzle();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #1_000_000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule